// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the program counter of an in-order fetch stage and chooses the address to fetch next. It has two tables, both direct-mapped and both indexed by low bits of the instruction address. The first holds one two-bit saturating counter per entry and gives the taken or not-taken guess. The second holds a valid bit, an address tag and a target address per entry. In the same cycle the fetch PC is presented, the block returns the next PC. That is the stored target when the target table hits and the counter predicts taken, and the sequential address otherwise. A taken branch that hits the target table therefore loses no cycle.

Later in the pipeline, the resolve port reports a branch that has been executed. It carries the branch address, the real direction, the real target and the next PC that fetch used after that branch. The block trains the counter towards the real outcome and fills the target table on taken branches. In the same cycle, combinationally, it raises a misprediction flag and gives the correct restart address, so the pipeline can flush. The flush itself and any global history lie outside the block.

Top module: `bpred_fetch_unit`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken) and every target entry is invalid. In that state pred_taken and btb_hit are 0 for any fetch_pc, and next_pc is fetch_pc + 4.
- R2: The direction counter for an address is selected by address bits [7:2] (64 entries). pred_taken is 1 exactly when that counter is 2 or 3.
- R3: Every resolve (res_valid=1) updates the counter selected by res_pc[7:2]. A taken outcome increments it and saturates at 3. A not-taken outcome decrements it and saturates at 0.
- R4: A counter at 3 keeps predicting taken after one not-taken outcome and predicts not taken after the second consecutive one. The opposite case, from 0, behaves the same way in reverse.
- R5: The target entry is selected by address bits [5:2] (16 entries) and tagged with bits [31:6]. btb_hit is 1 exactly when the selected entry is valid and its tag equals fetch_pc[31:6].
- R6: next_pc equals the stored target when btb_hit and pred_taken are both 1. Otherwise next_pc equals fetch_pc + 4. next_pc is valid in the same cycle as fetch_pc.
- R7: A resolve with res_taken=1 writes the entry selected by res_pc with valid=1, the tag of res_pc and res_target. A resolve with res_taken=0 leaves the target table unchanged.
- R8: The correct next address is res_target when res_taken=1, and res_pc + 4 otherwise. During a resolve, flush_pc shows this address and mispredict is 1 exactly when it differs from res_pred_npc. A wrong direction and a wrong target both count. mispredict is 0 when res_valid=0. Both outputs are combinational.
- R9: A fetch lookup in the same cycle as a resolve to the same entry sees the contents from before the update. The update is visible from the next cycle.
- R10: Two branch addresses that share a target index but have different tags do not hit on each other's entry. A taken resolve of the second address replaces the entry of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_taken | output | 1 | Direction guess for fetch_pc |
| btb_hit | output | 1 | Target table holds a valid entry for fetch_pc |
| next_pc | output | 32 | Address to fetch in the next cycle |
| res_valid | input | 1 | A resolved branch is reported this cycle |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Real direction of the resolved branch |
| res_target | input | 32 | Real target of the resolved branch |
| res_pred_npc | input | 32 | Next PC that fetch used after this branch |
| mispredict | output | 1 | Fetch went the wrong way; flush required |
| flush_pc | output | 32 | Correct address after the resolved branch |

## Verification
The assertions watch every cycle. They check that each counter moves exactly one step towards the reported outcome and holds at its limits. They check that a taken resolve leaves a valid entry carrying its target, and that the misprediction flag never rises without a resolve. Other behaviours appear only across several cycles and several addresses: the two-step hysteresis, aliasing between tags, the pre-update view when lookup and update collide, and a hit that stays without a redirect while the counter says not taken. The bench shows these with directed sequences and a random stream over a small address pool, compared each cycle against a behavioural model.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
   localparam int unsigned CTR_W = 2;
   typedef logic [CTR_W-1:0] ctr_t;
   localparam ctr_t CTR_TOP = '1;
   localparam ctr_t CTR_BOT = '0;

   function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
      ctr_t r;
      if (up) r = (cur == CTR_TOP) ? cur : cur + ctr_t'(1);
      else    r = (cur == CTR_BOT) ? cur : cur - ctr_t'(1);
      return r;
   endfunction
endpackage

// File: rtl/bpred_dir_table.sv
module bpred_dir_table
   import bpred_pkg::*;
#(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned IDX_W   = 6,
   parameter int unsigned ALIGN_W = 2,
   parameter int unsigned INIT    = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   input  logic            up_en,
   input  logic [PC_W-1:0] up_pc,
   input  logic            up_taken
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   if (IDX_W + ALIGN_W > PC_W) begin : g_bad_idx
      $error("bpred_dir_table: index does not fit in PC");
   end
   if (INIT > 3) begin : g_bad_init
      $error("bpred_dir_table: INIT out of counter range");
   end

   ctr_t             cnt_q [DEPTH];
   logic [IDX_W-1:0] lk_idx, up_idx;
   ctr_t             up_cur;

   assign lk_idx   = lk_pc[ALIGN_W +: IDX_W];
   assign up_idx   = up_pc[ALIGN_W +: IDX_W];
   assign lk_taken = cnt_q[lk_idx][CTR_W-1];
   assign up_cur   = cnt_q[up_idx];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q[e] <= ctr_t'(INIT);
         else if (up_en && up_idx == IDX_W'(e))
            cnt_q[e] <= ctr_step(cnt_q[e], up_taken);
      end
   end

   a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      (up_en && up_taken && up_cur != CTR_TOP) |=>
         cnt_q[$past(up_idx)] == $past(up_cur) + ctr_t'(1));
   a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (up_en && !up_taken && up_cur != CTR_BOT) |=>
         cnt_q[$past(up_idx)] == $past(up_cur) - ctr_t'(1));
   a_r3_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
      (up_en && up_taken && up_cur == CTR_TOP) |=> cnt_q[$past(up_idx)] == CTR_TOP);
   a_r3_hold_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (up_en && !up_taken && up_cur == CTR_BOT) |=> cnt_q[$past(up_idx)] == CTR_BOT);
endmodule

// File: rtl/bpred_tgt_buf.sv
module bpred_tgt_buf #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned ALIGN_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_hit,
   output logic [PC_W-1:0] lk_tgt,
   input  logic            wr_en,
   input  logic [PC_W-1:0] wr_pc,
   input  logic [PC_W-1:0] wr_tgt
);
   localparam int unsigned DEPTH = 1 << IDX_W;
   localparam int unsigned TAG_W = PC_W - IDX_W - ALIGN_W;
   localparam int unsigned TAG_LO = IDX_W + ALIGN_W;

   if (TAG_W < 1) begin : g_bad_tag
      $error("bpred_tgt_buf: no tag bits left");
   end

   logic             vld_q [DEPTH];
   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [PC_W-1:0]  tgt_q [DEPTH];
   logic [IDX_W-1:0] lk_idx, wr_idx;
   logic [TAG_W-1:0] lk_tag, wr_tag;

   assign lk_idx = lk_pc[ALIGN_W +: IDX_W];
   assign wr_idx = wr_pc[ALIGN_W +: IDX_W];
   assign lk_tag = lk_pc[PC_W-1:TAG_LO];
   assign wr_tag = wr_pc[PC_W-1:TAG_LO];
   assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign lk_tgt = tgt_q[lk_idx];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[e] <= 1'b0;
            tag_q[e] <= '0;
            tgt_q[e] <= '0;
         end else if (wr_en && wr_idx == IDX_W'(e)) begin
            vld_q[e] <= 1'b1;
            tag_q[e] <= wr_tag;
            tgt_q[e] <= wr_tgt;
         end
      end
   end

   a_r7_fill: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vld_q[$past(wr_idx)] && tgt_q[$past(wr_idx)] == $past(wr_tgt)
               && tag_q[$past(wr_idx)] == $past(wr_tag));
   a_r7_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> vld_q[$past(lk_idx)] == $past(vld_q[lk_idx]));
endmodule

// File: rtl/bpred_resolve.sv
module bpred_resolve #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned ALIGN_W = 2
) (
   input  logic            res_valid,
   input  logic [PC_W-1:0] res_pc,
   input  logic            res_taken,
   input  logic [PC_W-1:0] res_target,
   input  logic [PC_W-1:0] res_pred_npc,
   output logic            mispredict,
   output logic [PC_W-1:0] flush_pc
);
   localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN_W;

   logic [PC_W-1:0] seq_pc;
   assign seq_pc     = res_pc + STEP;
   assign flush_pc   = res_taken ? res_target : seq_pc;
   assign mispredict = res_valid && (flush_pc != res_pred_npc);
endmodule

// File: rtl/bpred_fetch_unit.sv
module bpred_fetch_unit #(
   parameter int unsigned PC_W       = 32,
   parameter int unsigned DIR_IDX_W  = 6,
   parameter int unsigned TGT_IDX_W  = 4,
   parameter int unsigned ALIGN_W    = 2,
   parameter int unsigned CTR_INIT   = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic            pred_taken,
   output logic            btb_hit,
   output logic [PC_W-1:0] next_pc,
   input  logic            res_valid,
   input  logic [PC_W-1:0] res_pc,
   input  logic            res_taken,
   input  logic [PC_W-1:0] res_target,
   input  logic [PC_W-1:0] res_pred_npc,
   output logic            mispredict,
   output logic [PC_W-1:0] flush_pc
);
   localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN_W;

   if (ALIGN_W >= PC_W) begin : g_bad_align
      $error("bpred_fetch_unit: ALIGN_W too large");
   end

   logic [PC_W-1:0] hit_tgt;

   bpred_dir_table #(
      .PC_W(PC_W), .IDX_W(DIR_IDX_W), .ALIGN_W(ALIGN_W), .INIT(CTR_INIT)
   ) u_dir (
      .clk(clk), .rst_n(rst_n),
      .lk_pc(fetch_pc), .lk_taken(pred_taken),
      .up_en(res_valid), .up_pc(res_pc), .up_taken(res_taken)
   );

   bpred_tgt_buf #(
      .PC_W(PC_W), .IDX_W(TGT_IDX_W), .ALIGN_W(ALIGN_W)
   ) u_tgt (
      .clk(clk), .rst_n(rst_n),
      .lk_pc(fetch_pc), .lk_hit(btb_hit), .lk_tgt(hit_tgt),
      .wr_en(res_valid && res_taken), .wr_pc(res_pc), .wr_tgt(res_target)
   );

   bpred_resolve #(
      .PC_W(PC_W), .ALIGN_W(ALIGN_W)
   ) u_res (
      .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
      .res_target(res_target), .res_pred_npc(res_pred_npc),
      .mispredict(mispredict), .flush_pc(flush_pc)
   );

   assign next_pc = (btb_hit && pred_taken) ? hit_tgt : fetch_pc + STEP;

   a_r8_needs_resolve: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |-> res_valid);
   a_r6_redirect_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (next_pc != fetch_pc + STEP) |-> (btb_hit && pred_taken));
endmodule

// File: tb/bpred_fetch_unit_tb.sv
module bpred_fetch_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        pred_taken, btb_hit, mispredict;
   logic [31:0] next_pc, flush_pc;
   logic        res_valid = 1'b0;
   logic [31:0] res_pc = '0;
   logic        res_taken = 1'b0;
   logic [31:0] res_target = '0;
   logic [31:0] res_pred_npc = '0;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   int          m_cnt [64];
   bit          m_vld [16];
   logic [25:0] m_tag [16];
   logic [31:0] m_tgt [16];

   always #5 clk = ~clk;

   bpred_fetch_unit u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
      .btb_hit(btb_hit), .next_pc(next_pc), .res_valid(res_valid), .res_pc(res_pc),
      .res_taken(res_taken), .res_target(res_target), .res_pred_npc(res_pred_npc),
      .mispredict(mispredict), .flush_pc(flush_pc)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int hidx(input logic [31:0] pc); return int'(pc[7:2]); endfunction
   function automatic int bidx(input logic [31:0] pc); return int'(pc[5:2]); endfunction

   // Drive one cycle, compare against the model, then commit the model at the edge.
   task automatic step(input logic [31:0] fpc, input bit rv, input logic [31:0] rpc,
                       input bit rtk, input logic [31:0] rtgt, input logic [31:0] rnpc);
      bit          e_tk, e_hit;
      logic [31:0] e_npc, e_fl;
      @(negedge clk);
      fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rtk;
      res_target = rtgt; res_pred_npc = rnpc;
      #2;
      e_tk  = m_cnt[hidx(fpc)] >= 2;
      e_hit = m_vld[bidx(fpc)] && m_tag[bidx(fpc)] == fpc[31:6];
      e_npc = (e_tk && e_hit) ? m_tgt[bidx(fpc)] : fpc + 32'd4;
      e_fl  = rtk ? rtgt : rpc + 32'd4;
      chk("R2 R4 pred_taken", {31'd0, pred_taken}, {31'd0, e_tk});
      chk("R5 R10 btb_hit", {31'd0, btb_hit}, {31'd0, e_hit});
      chk("R6 next_pc", next_pc, e_npc);
      chk("R8 mispredict", {31'd0, mispredict}, {31'd0, rv && (e_fl != rnpc)});
      if (rv) chk("R8 flush_pc", flush_pc, e_fl);
      @(posedge clk);
      if (rv) begin
         if (rtk) begin
            if (m_cnt[hidx(rpc)] < 3) m_cnt[hidx(rpc)]++;
            m_vld[bidx(rpc)] = 1;
            m_tag[bidx(rpc)] = rpc[31:6];
            m_tgt[bidx(rpc)] = rtgt;
         end else if (m_cnt[hidx(rpc)] > 0) m_cnt[hidx(rpc)]--;
      end
   endtask

   task automatic idle_look(input logic [31:0] fpc);
      step(fpc, 0, 32'h0, 0, 32'h0, 32'h0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) m_cnt[i] = 1;
      for (int i = 0; i < 16; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; end
      repeat (2) @(posedge clk);
      #1;
      // R1: reset state, literal expectations
      fetch_pc = 32'h0000_1040;
      #1;
      chk("R1 pred_taken after reset", {31'd0, pred_taken}, 32'd0);
      chk("R1 btb_hit after reset", {31'd0, btb_hit}, 32'd0);
      chk("R1 next_pc after reset", next_pc, 32'h0000_1044);
      @(negedge clk); rst_n = 1'b1;

      // R3 R4: strong taken then two not-taken outcomes
      step(32'h100, 1, 32'h100, 1, 32'h800, 32'h104); // miss: mispredict
      step(32'h100, 1, 32'h100, 1, 32'h800, 32'h104);
      step(32'h100, 1, 32'h100, 1, 32'h800, 32'h800);
      step(32'h100, 1, 32'h100, 1, 32'h800, 32'h800); // saturate at 3
      #1; chk("R6 hit redirects to target", next_pc, 32'h800);
      step(32'h100, 1, 32'h100, 0, 32'h800, 32'h800); // 3 -> 2
      #1; chk("R4 still taken after one miss", {31'd0, pred_taken}, 32'd1);
      step(32'h100, 1, 32'h100, 0, 32'h800, 32'h800); // 2 -> 1
      #1; chk("R4 flips after second miss", {31'd0, pred_taken}, 32'd0);
      chk("R7 not-taken keeps entry", {31'd0, btb_hit}, 32'd1);
      chk("R6 no redirect when not taken", next_pc, 32'h104);
      // R3 low saturation
      step(32'h100, 1, 32'h100, 0, 32'h800, 32'h104);
      step(32'h100, 1, 32'h100, 0, 32'h800, 32'h104);
      step(32'h100, 1, 32'h100, 1, 32'h800, 32'h104); // 0 -> 1
      #1; chk("R3 bottom saturation", {31'd0, pred_taken}, 32'd0);

      // R8 target mismatch with correct direction
      step(32'h0, 1, 32'h100, 1, 32'h900, 32'h800);
      step(32'h100, 1, 32'h100, 1, 32'h900, 32'h900);

      // R9: lookup and update same entry in same cycle see old contents
      step(32'h240, 1, 32'h240, 1, 32'hA00, 32'h244);
      step(32'h240, 1, 32'h240, 1, 32'hA00, 32'h244);
      @(negedge clk);
      fetch_pc = 32'h240; res_valid = 1; res_pc = 32'h240; res_taken = 1;
      res_target = 32'hA00; res_pred_npc = 32'hA00;
      #1; chk("R9 pre-update view", next_pc, 32'hA00);
      @(posedge clk); if (m_cnt[hidx(32'h240)] < 3) m_cnt[hidx(32'h240)]++;

      // R10: alias 0x240 and 0x1240 share index 0 of target table
      idle_look(32'h1240);
      #1; chk("R10 alias misses", {31'd0, btb_hit}, 32'd0);
      step(32'h1240, 1, 32'h1240, 1, 32'hB00, 32'h1244);
      idle_look(32'h240);
      #1; chk("R10 replaced entry misses", {31'd0, btb_hit}, 32'd0);

      // random stream over a small address pool
      for (int n = 0; n < 400; n++) begin
         logic [31:0] fp, rp, tg, np;
         bit          rv, rt;
         fp = {22'd0, 4'($urandom_range(0, 3)), 4'($urandom_range(0, 5)), 2'b00};
         rp = {22'd0, 4'($urandom_range(0, 3)), 4'($urandom_range(0, 5)), 2'b00};
         tg = {20'd0, 4'($urandom_range(0, 15)), 6'd0, 2'b00};
         rv = $urandom_range(0, 3) != 0;
         rt = $urandom_range(0, 1) == 1;
         np = $urandom_range(0, 1) ? (rt ? tg : rp + 32'd4) : tg ^ 32'h40;
         step(fp, rv, rp, rt, tg, np);
      end
      done = 1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule